// File: doc/BRIEF.md
# Channel Exit Context Save Sequencer

This block carries out the end-of-program sequence of one channel of a small multi-channel peripheral processor. When the channel program leaves, either through a normal exit request or through an error abort, the sequencer patches the program-counter/enable register and can raise a service request toward one of several request outputs. It then copies the channel's working registers into a context memory, one word per clock.

The block keeps a dirty bit for each working register. A context restore clears every dirty bit, and any later register write sets the bit for that register. At exit only dirty registers are written back, and only those inside the context size the channel is configured for. The two control registers are always written, because the exit sequence itself modifies them. The processor stalls while the sequencer is busy. It sees `done` for one cycle when the last context word has been stored.

Top module: `exit_seq`

## Requirements
- R1: An exit request with `exit_stop`=1 stores register 7 with its enable bit (bit 0) cleared. With `exit_stop`=0 the enable bit keeps its value.
- R2: If `exit_ep`=0 or `resume_mode`=0, the program counter field of register 7 (bits PCW:1) is saved as `entry_pc`. Bits above the field are kept.
- R3: If `exit_ep`=1 and `resume_mode`=1, the program counter field is saved as `next_pc`.
- R4: An exit with `exit_int`=1 and `exit_cond`=1 produces a one-cycle service request one cycle after acceptance, with `srq_prio` equal to register 6 bits 7:0. In every other case no request is raised.
- R5: Register 6 bit 8 selects the lower half (0) or the upper half (1) of `srq`. The request goes to the lowest-numbered output in that half whose `free_mask` bit is 1.
- R6: If a request is due and the selected half has no free output, `err_status[2]` is set and stays set until reset, and `srq` stays 0.
- R7: `ctx_mode` 00 makes registers 0-7 eligible, 01 makes registers 4-7 eligible, and 10 or 11 makes registers 6-7 eligible. Registers 6 and 7 are written at every exit and every abort.
- R8: Only eligible registers that have been written since the last `restore` are saved. They are saved in ascending index order, one per clock, and each saved register becomes clean.
- R9: `err_req` aborts the channel. `err_cause` is stored in `err_status[1:0]`, and register 7 is saved with its enable bit cleared and its program counter unchanged. An abort takes priority over a simultaneous exit request and raises no service request.
- R10: `busy` rises the cycle after acceptance and stays high through the last context write. `done` then pulses for one cycle with `busy` low, so `busy` is high for one more cycle than there are writes.
- R11: Each context write puts `{chan_id, register index}` on `mem_addr` and the register value on `mem_wdata`.
- R12: `reg_we` and `restore` have no effect while the sequencer is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exit_req | input | 1 | Normal exit request, one cycle |
| exit_stop | input | 1 | Disable the channel at this exit |
| exit_ep | input | 1 | Save the next-instruction address if resume mode is set |
| exit_int | input | 1 | Request a service interrupt |
| exit_cond | input | 1 | Condition result that gates the interrupt |
| err_req | input | 1 | Error abort, one cycle |
| err_cause | input | 2 | Abort cause code (01 illegal opcode, 10 bus error) |
| resume_mode | input | 1 | 1 resume, 0 restart |
| ctx_mode | input | 2 | Context size select |
| chan_id | input | CHW | Channel number, used in the context address |
| entry_pc | input | PCW | Channel entry address |
| next_pc | input | PCW | Address after the exit instruction |
| free_mask | input | NSRC | Free request entries |
| reg_we | input | 1 | Register file write |
| reg_waddr | input | IW | Register file write index |
| reg_wdata | input | DW | Register file write data |
| restore | input | 1 | Context restored; clears all dirty bits |
| busy | output | 1 | Exit sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_we | output | 1 | Context memory write enable |
| mem_addr | output | CHW+IW | Context memory address |
| mem_wdata | output | DW | Context memory write data |
| srq | output | NSRC | One-hot service request pulse |
| srq_prio | output | 8 | Priority number sent with the request |
| err_status | output | 3 | [1:0] last abort cause, [2] request overflow |

## Verification
The assertions assume that `exit_req` and `err_req` arrive only while `busy` and `done` are low, that each is a single-cycle pulse, and that the configuration inputs stay steady from acceptance until `done`. The bench waits for `done` and one idle cycle before each new request. It changes configuration only between sequences. It loads the register file and issues `restore` before each scenario, so that the dirty state it expects is the one it built itself.

// File: rtl/exit_pkg.sv
package exit_pkg;
  typedef enum logic {S_IDLE = 1'b0, S_SAVE = 1'b1} seq_state_t;
  localparam int SRPN_W  = 8;
  localparam int TOS_BIT = 8;
endpackage

// File: rtl/ctx_regfile.sv
module ctx_regfile #(
  parameter int DW = 32,
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [N-1:0]  dirty_set,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  input  logic          restore,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] r6,
  output logic [DW-1:0] r7,
  output logic [N-1:0]  dirty
);
  logic [DW-1:0] regs [N];
  logic [N-1:0]  set_m, clr_m;

  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  always_comb begin
    set_m = dirty_set;
    clr_m = '0;
    if (we)     set_m[waddr]  = 1'b1;
    if (clr_en) clr_m[clr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || restore) dirty <= '0;
    else                dirty <= (dirty | set_m) & ~clr_m;
  end

  assign rd_data = regs[rd_idx];
  assign r6      = regs[N-2];
  assign r7      = regs[N-1];
endmodule

// File: rtl/srq_select.sv
module srq_select #(
  parameter int NSRC = 4
) (
  input  logic            tos,
  input  logic [NSRC-1:0] free_mask,
  output logic            found,
  output logic [NSRC-1:0] onehot
);
  localparam int HALF = NSRC / 2;
  logic [NSRC-1:0] cand;

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      cand[i] = free_mask[i] && ((i >= HALF) == tos);
    onehot = '0;
    found  = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && !found) begin
        onehot[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/exit_seq.sv
module exit_seq #(
  parameter int DW      = 32,
  parameter int PCW     = 16,
  parameter int NCH     = 4,
  parameter int NSRC    = 4,
  parameter int FULL_N  = 8,
  parameter int SMALL_N = 4,
  parameter int MIN_N   = 2,
  localparam int CHW    = $clog2(NCH),
  localparam int IW     = $clog2(FULL_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exit_req,
  input  logic              exit_stop,
  input  logic              exit_ep,
  input  logic              exit_int,
  input  logic              exit_cond,
  input  logic              err_req,
  input  logic [1:0]        err_cause,
  input  logic              resume_mode,
  input  logic [1:0]        ctx_mode,
  input  logic [CHW-1:0]    chan_id,
  input  logic [PCW-1:0]    entry_pc,
  input  logic [PCW-1:0]    next_pc,
  input  logic [NSRC-1:0]   free_mask,
  input  logic              reg_we,
  input  logic [IW-1:0]     reg_waddr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              restore,
  output logic              busy,
  output logic              done,
  output logic              mem_we,
  output logic [CHW+IW-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic [NSRC-1:0]   srq,
  output logic [7:0]        srq_prio,
  output logic [2:0]        err_status
);
  import exit_pkg::*;

  localparam int NREG = FULL_N;

  function automatic logic [NREG-1:0] elig_mask(input int size);
    logic [NREG-1:0] m;
    for (int i = 0; i < NREG; i++) m[i] = (i >= NREG - size);
    return m;
  endfunction

  seq_state_t      state;
  logic            idle, start_err, start_exit, start;
  logic [NREG-1:0] elig_q, elig_d, pending, ctl_set;
  logic [IW-1:0]   pick;
  logic            any;
  logic [DW-1:0]   r6, r7, rd_data, r7_new;
  logic [NREG-1:0] dirty;
  logic            rf_we;
  logic [IW-1:0]   rf_waddr;
  logic [DW-1:0]   rf_wdata;
  logic            srq_found;
  logic [NSRC-1:0] srq_hot;
  logic [CHW-1:0]  chan_q;
  logic [PCW-1:0]  pc_sel;

  assign idle       = (state == S_IDLE);
  assign start_err  = idle && err_req;
  assign start_exit = idle && exit_req && !err_req;
  assign start      = start_err || start_exit;

  always_comb begin
    case (ctx_mode)
      2'b00:   elig_d = elig_mask(FULL_N);
      2'b01:   elig_d = elig_mask(SMALL_N);
      default: elig_d = elig_mask(MIN_N);
    endcase
  end

  // New control register value produced by the exit or abort
  always_comb begin
    pc_sel = (exit_ep && resume_mode) ? next_pc : entry_pc;
    if (start_err) r7_new = {r7[DW-1:1], 1'b0};
    else           r7_new = {r7[DW-1:PCW+1], pc_sel, r7[0] & ~exit_stop};
  end

  always_comb begin
    ctl_set = '0;
    if (start) begin
      ctl_set[NREG-1] = 1'b1;
      ctl_set[NREG-2] = 1'b1;
    end
    rf_we    = start || (reg_we && idle);
    rf_waddr = start ? IW'(NREG-1) : reg_waddr;
    rf_wdata = start ? r7_new : reg_wdata;
  end

  // Lowest pending register first
  always_comb begin
    pending = dirty & elig_q;
    any     = |pending;
    pick    = '0;
    for (int i = NREG-1; i >= 0; i--)
      if (pending[i]) pick = IW'(i);
  end

  ctx_regfile #(.DW(DW), .N(NREG)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .we        (rf_we),
    .waddr     (rf_waddr),
    .wdata     (rf_wdata),
    .dirty_set (ctl_set),
    .clr_en    (!idle && any),
    .clr_idx   (pick),
    .restore   (restore && idle),
    .rd_idx    (pick),
    .rd_data   (rd_data),
    .r6        (r6),
    .r7        (r7),
    .dirty     (dirty)
  );

  srq_select #(.NSRC(NSRC)) u_srq (
    .tos       (r6[TOS_BIT]),
    .free_mask (free_mask),
    .found     (srq_found),
    .onehot    (srq_hot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      elig_q     <= '0;
      chan_q     <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      srq        <= '0;
      srq_prio   <= '0;
      err_status <= '0;
    end else begin
      done   <= 1'b0;
      mem_we <= 1'b0;
      srq    <= '0;
      if (start) begin
        state  <= S_SAVE;
        busy   <= 1'b1;
        elig_q <= elig_d;
        chan_q <= chan_id;
        if (start_err) err_status[1:0] <= err_cause;
        if (start_exit && exit_int && exit_cond) begin
          if (srq_found) begin
            srq      <= srq_hot;
            srq_prio <= r6[SRPN_W-1:0];
          end else begin
            err_status[2] <= 1'b1;
          end
        end
      end else if (!idle) begin
        if (any) begin
          mem_we    <= 1'b1;
          mem_addr  <= {chan_q, pick};
          mem_wdata <= rd_data;
        end else begin
          state <= S_IDLE;
          busy  <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/exit_seq_chk.sv
module exit_seq_chk #(
  parameter int NSRC = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            done,
  input logic            mem_we,
  input logic [NSRC-1:0] srq,
  input logic [2:0]      err_status
);
  assert_srq_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(srq));
  assert_write_in_busy_R10: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_ovf_no_srq_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(err_status[2]) |-> (srq == '0));
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    err_status[2] |=> err_status[2]);
endmodule

bind exit_seq exit_seq_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .mem_we(mem_we), .srq(srq), .err_status(err_status)
);

// File: tb/tb_exit_seq.sv
`timescale 1ns/1ps
module tb_exit_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        exit_req, exit_stop, exit_ep, exit_int, exit_cond;
  logic        err_req;
  logic [1:0]  err_cause;
  logic        resume_mode;
  logic [1:0]  ctx_mode;
  logic [1:0]  chan_id;
  logic [15:0] entry_pc, next_pc;
  logic [3:0]  free_mask;
  logic        reg_we;
  logic [2:0]  reg_waddr;
  logic [31:0] reg_wdata;
  logic        restore;
  logic        busy, done, mem_we;
  logic [4:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  srq;
  logic [7:0]  srq_prio;
  logic [2:0]  err_status;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  exit_seq dut (.*);

  always #2.5 clk = ~clk;

  // capture
  logic [4:0]  wa [16];
  logic [31:0] wd [16];
  int          wn, busy_n, done_n, srq_n;
  logic [3:0]  srq_v;
  logic [7:0]  prio_v;

  always @(negedge clk) begin
    if (mem_we && wn < 16) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; wn++; end
    if (busy) busy_n++;
    if (done) done_n++;
    if (srq != 0) begin srq_n++; srq_v = srq; prio_v = srq_prio; end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  localparam logic [31:0] R7_INIT = 32'h0000_0201; // pc 0x0100, enable 1

  task automatic load_regs(input logic tos);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      reg_we = 1; reg_waddr = 3'(i);
      reg_wdata = (i == 7) ? R7_INIT : (i == 6) ? {23'h0, tos, 8'h5A} : 32'hA000_0000 + i;
    end
    @(negedge clk); reg_we = 0; restore = 1;
    @(negedge clk); restore = 0;
  endtask

  task automatic wreg(input int idx, input logic [31:0] v);
    @(negedge clk); reg_we = 1; reg_waddr = 3'(idx); reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic run(input logic st, input logic ep, input logic it, input logic cd, input logic er);
    @(posedge clk); #1;
    wn = 0; busy_n = 0; done_n = 0; srq_n = 0; srq_v = 0; prio_v = 0;
    @(negedge clk);
    exit_req = 1; exit_stop = st; exit_ep = ep; exit_int = it; exit_cond = cd; err_req = er;
    @(negedge clk);
    exit_req = 0; err_req = 0;
    for (int k = 0; k < 40 && done_n == 0; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R10 busy at reset", 32'(busy), 0);
    check("R10 done at reset", 32'(done), 0);
    check("R4 srq at reset", 32'(srq), 0);
    check("R6 err_status at reset", 32'(err_status), 0);
  endtask

  task automatic t_stop_min;
    load_regs(0); ctx_mode = 2'b10; resume_mode = 0;
    run(1, 0, 0, 0, 0);
    check("R7 min writes", wn, 2);
    check("R11 addr r6", 32'(wa[0]), 32'h16);
    check("R11 addr r7", 32'(wa[1]), 32'h17);
    check("R1 R2 saved r7 stop", wd[1], 32'h0000_0080);
    check("R10 busy length", busy_n, wn + 1);
    check("R10 done pulse", done_n, 1);
  endtask

  task automatic t_pc_rules;
    load_regs(0); ctx_mode = 2'b10; resume_mode = 1;
    run(0, 1, 0, 0, 0);
    check("R3 resume next pc", wd[1], 32'h0000_0247);
    load_regs(0); resume_mode = 0;
    run(0, 1, 0, 0, 0);
    check("R2 restart entry pc", wd[1], 32'h0000_0081);
    load_regs(0); resume_mode = 1;
    run(0, 0, 0, 0, 0);
    check("R2 ep0 entry pc", wd[1], 32'h0000_0081);
  endtask

  task automatic t_srq;
    load_regs(1); ctx_mode = 2'b10; free_mask = 4'b1010;
    run(0, 0, 1, 1, 0);
    check("R5 upper half pick", 32'(srq_v), 32'h8);
    check("R4 prio", 32'(prio_v), 32'h5A);
    check("R4 single pulse", srq_n, 1);
    load_regs(0); free_mask = 4'b1011;
    run(0, 0, 1, 1, 0);
    check("R5 lower half pick", 32'(srq_v), 32'h1);
    run(0, 0, 1, 0, 0);
    check("R4 cond false no srq", srq_n, 0);
    run(0, 0, 0, 1, 0);
    check("R4 int clear no srq", srq_n, 0);
    check("R6 no overflow yet", 32'(err_status[2]), 0);
  endtask

  task automatic t_overflow;
    load_regs(0); free_mask = 4'b1100;
    run(0, 0, 1, 1, 0);
    check("R6 no srq on overflow", srq_n, 0);
    check("R6 overflow flag", 32'(err_status[2]), 1);
    free_mask = 4'b1111;
    run(0, 0, 0, 0, 0);
    check("R6 overflow sticky", 32'(err_status[2]), 1);
  endtask

  task automatic t_dirty;
    load_regs(0); resume_mode = 0;
    wreg(2, 32'h1111_2222); wreg(5, 32'h3333_4444);
    ctx_mode = 2'b01;
    run(0, 0, 0, 0, 0);
    check("R7 small count", wn, 3);
    check("R8 small first r5", 32'(wa[0]), 32'h15);
    check("R8 r5 data", wd[0], 32'h3333_4444);
    check("R7 small r6 second", 32'(wa[1]), 32'h16);
    load_regs(0);
    wreg(2, 32'h1111_2222); wreg(5, 32'h3333_4444);
    ctx_mode = 2'b00;
    run(0, 0, 0, 0, 0);
    check("R7 full count", wn, 4);
    check("R8 full order r2", 32'(wa[0]), 32'h12);
    check("R8 full order r5", 32'(wa[1]), 32'h15);
    run(0, 0, 0, 0, 0);
    check("R8 saved become clean", wn, 2);
    check("R10 busy length full", busy_n, 3);
    wreg(3, 32'h5); @(negedge clk); restore = 1; @(negedge clk); restore = 0;
    run(0, 0, 0, 0, 0);
    check("R8 restore clears dirty", wn, 2);
  endtask

  task automatic t_busy_ignore;
    load_regs(0); ctx_mode = 2'b00;
    @(posedge clk); #1;
    wn = 0; done_n = 0;
    @(negedge clk); exit_req = 1; exit_stop = 0; exit_ep = 0; exit_int = 0; exit_cond = 0;
    @(negedge clk); exit_req = 0; reg_we = 1; reg_waddr = 3'd3; reg_wdata = 32'hDEAD;
    @(negedge clk); reg_we = 0;
    for (int k = 0; k < 40 && done_n == 0; k++) @(negedge clk);
    @(negedge clk);
    run(0, 0, 0, 0, 0);
    check("R12 busy write ignored count", wn, 2);
    check("R12 busy write ignored addr", 32'(wa[0]), 32'h16);
    load_regs(0); wreg(3, 32'h77);
    @(posedge clk); #1; done_n = 0;
    @(negedge clk); exit_req = 1;
    @(negedge clk); exit_req = 0; restore = 1;
    @(negedge clk); restore = 0;
    for (int k = 0; k < 40 && done_n == 0; k++) @(negedge clk);
    @(negedge clk);
    load_regs(0); wreg(3, 32'h77);
    run(0, 0, 0, 0, 0);
    check("R12 reference dirty r3 saved", 32'(wa[0]), 32'h13);
  endtask

  task automatic t_error;
    load_regs(0); ctx_mode = 2'b10; resume_mode = 1; free_mask = 4'b1111;
    run(0, 1, 1, 1, 1);
    err_cause = 2'b10;
    check("R9 err beats exit no srq", srq_n, 0);
    check("R9 saved r7 enable clear", wd[1], 32'h0000_0200);
    check("R9 cause recorded", 32'(err_status[1:0]), 32'h1);
    run(0, 0, 0, 0, 1);
    check("R9 cause updated", 32'(err_status[1:0]), 32'h2);
  endtask

  initial begin
    rst = 1; exit_req = 0; exit_stop = 0; exit_ep = 0; exit_int = 0; exit_cond = 0;
    err_req = 0; err_cause = 2'b01; resume_mode = 0; ctx_mode = 0; chan_id = 2'd2;
    entry_pc = 16'h0040; next_pc = 16'h0123; free_mask = 4'b1111;
    reg_we = 0; reg_waddr = 0; reg_wdata = 0; restore = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_stop_min;
    t_pc_rules;
    t_srq;
    t_overflow;
    t_dirty;
    t_busy_ignore;
    t_error;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule